// File: doc/BRIEF.md
# Sequential Streaming Read Prefetcher

This block sits in front of the user port of a DRAM controller and turns it into a steady stream of 32-bit words. At start-up it takes a preload image from a fill stream and writes it into memory between a base and an end byte address. Each write command covers a group of words and addresses follow one another. After the last write command the block only reads. It walks the same window with rising read addresses, wraps from the end back to the base, and copies returned data into a local FIFO that feeds a valid/ready consumer.

Read commands are sized and issued against the room left in the local FIFO. Every word that has been requested but has not yet come back already holds a slot. Data held back by a refresh or a page miss therefore always has a place to land, and the FIFO can never overflow. Every burst holds an even number of words, so a 16-bit DDR2 device with a burst of four never performs a half-used access. The output stream starts only once the FIFO has filled to a programmable level. Any underflow after that point is latched as an error.

Top module: `strm_pf_top`

## Requirements
- R1: In the fill phase each accepted fill word appears on the write-data port in the same cycle, in order. A write command (instruction code 3'b000) is issued after every MAX_BURST accepted words, and again after the last word of the image if fewer remain. Its byte address is base plus four times the index of the burst's first word, and its length field equals the word count minus one.
- R2: After the write command carrying the last image word, every command uses instruction code 3'b001 (read); no write command is ever issued again.
- R3: The first read address is the base. Each further read address is the previous one plus four times that burst's word count. When this sum reaches the end address, the next read address is the base again.
- R4: A read burst holds the smaller of MAX_BURST and the number of words left before the end address, so no burst crosses the end. With base and end multiples of 8 bytes, every length field is odd (an even word count).
- R5: In the read phase a read command is issued exactly when cmdFull is low and the free local FIFO space (DEPTH minus stored words) is at least the words still outstanding plus the new burst's word count. The local FIFO therefore never holds more than DEPTH words.
- R6: In the read phase rdEn equals the inverse of rdEmpty. Every word popped from the controller enters the local FIFO, and the words come out in the order returned.
- R7: outValid stays low until the stored word count has reached startLevel at a clock edge. From then on it is high whenever the FIFO is not empty. The data follows the image order and wraps after the last word.
- R8: Once streaming has started, a cycle with outReady high and an empty FIFO sets underflowErr, and it stays set until reset.
- R9: While reset is held, outValid, cmdEn, rdEn, wrEn and underflowErr are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; loads the base address |
| baseAddr | input | ADDR_W | First byte address of the window (multiple of 8) |
| endAddr | input | ADDR_W | Byte address one past the window (multiple of 8) |
| startLevel | input | clog2(DEPTH+1) | Stored-word count that starts the stream |
| fillValid | input | 1 | Preload word present |
| fillData | input | DATA_W | Preload word |
| fillReady | output | 1 | Preload word accepted this cycle when valid |
| wrEn | output | 1 | Push into the controller write-data queue |
| wrData | output | DATA_W | Write-data word |
| cmdEn | output | 1 | Command issued this cycle |
| cmdInstr | output | 3 | 3'b000 write, 3'b001 read |
| cmdAddr | output | ADDR_W | Command byte address |
| cmdBl | output | 6 | Word count minus one |
| cmdFull | input | 1 | Controller cannot take a command |
| rdEn | output | 1 | Pop the controller read-data queue |
| rdData | input | DATA_W | Head of the controller read-data queue |
| rdEmpty | input | 1 | Controller read-data queue empty |
| outValid | output | 1 | Stream word present |
| outData | output | DATA_W | Stream word |
| outReady | input | 1 | Consumer takes the word |
| underflowErr | output | 1 | Sticky underflow after start |

## Verification
The hardest state to reach is an empty FIFO after streaming has begun. The reservation rule is built to keep that from happening, so a correct design avoids it until the memory side stops completely. The stimulus first runs a long stretch in which the consumer takes three words in four while the memory model injects periodic 40-cycle refresh freezes and 20-cycle page-miss delays, and the command port is refused now and then; the error must stay clear through all of it. The model then freezes all returns while the consumer pulls every cycle, which drains the FIFO and must set the error. A 200-word window with 32-word bursts forces a shortened 8-word burst before every wrap, in both the fill and the read phase.

// File: rtl/strm_pf_pkg.sv
package strm_pf_pkg;

  typedef enum logic [2:0] {
    CMD_WRITE = 3'b000,
    CMD_READ  = 3'b001
  } cmdOp_e;

  typedef enum logic {
    PH_FILL = 1'b0,
    PH_READ = 1'b1
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic wrPass;  // fill word forwarded to controller write queue
    logic xfer;    // controller read word moved into the local FIFO
  } pfStrobe_t;

endpackage

// File: rtl/strm_pf_ctrl.sv
module strm_pf_ctrl
  import strm_pf_pkg::*;
#(
  parameter int ADDR_W    = 30,
  parameter int DEPTH     = 128,
  parameter int MAX_BURST = 32,
  parameter int LVL_W     = 8,
  parameter int BL_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic              fillValid,
  output logic              fillReady,
  output logic              cmdEn,
  output logic [2:0]        cmdInstr,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [BL_W-1:0]   cmdBl,
  input  logic              cmdFull,
  input  logic              rdEmpty,
  output logic              rdEn,
  input  logic [LVL_W-1:0]  fifoLevel,
  output pfStrobe_t         strobe
);

  localparam int BC_W  = $clog2(MAX_BURST + 1);
  localparam int SUM_W = LVL_W + 1;

  phase_e            phase;
  logic [ADDR_W-1:0] wrAddr, rdAddr, fillAddr, rdNext, remWords;
  logic [BC_W-1:0]   burstCnt, rdWords, cmdWords;
  logic [LVL_W-1:0]  outstanding;
  logic [SUM_W-1:0]  room, need;
  logic              imageDone, wrCmdWant, rdWant, issue;

  // fill-side decisions
  always_comb begin
    fillAddr  = wrAddr + (ADDR_W'(burstCnt) << 2);
    imageDone = (fillAddr == endAddr);
    wrCmdWant = (phase == PH_FILL) &&
                ((burstCnt == BC_W'(MAX_BURST)) || (imageDone && (burstCnt != '0)));
    fillReady = (phase == PH_FILL) && !wrCmdWant && !imageDone;
  end

  // read-side sizing against FIFO headroom
  always_comb begin
    remWords = (endAddr - rdAddr) >> 2;
    rdWords  = (remWords > ADDR_W'(MAX_BURST)) ? BC_W'(MAX_BURST) : BC_W'(remWords);
    room     = SUM_W'(DEPTH) - SUM_W'(fifoLevel);
    need     = SUM_W'(outstanding) + SUM_W'(rdWords);
    rdWant   = (phase == PH_READ) && (room >= need);
    rdNext   = rdAddr + (ADDR_W'(rdWords) << 2);
  end

  always_comb begin
    issue         = (wrCmdWant || rdWant) && !cmdFull;
    cmdWords      = (phase == PH_FILL) ? burstCnt : rdWords;
    cmdEn         = issue;
    cmdInstr      = (phase == PH_FILL) ? CMD_WRITE : CMD_READ;
    cmdAddr       = (phase == PH_FILL) ? wrAddr : rdAddr;
    cmdBl         = BL_W'(cmdWords - BC_W'(1));
    rdEn          = (phase == PH_READ) && !rdEmpty;
    strobe.wrPass = fillValid && fillReady;
    strobe.xfer   = rdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_FILL;
      wrAddr      <= baseAddr;
      rdAddr      <= baseAddr;
      burstCnt    <= '0;
      outstanding <= '0;
    end else begin
      if (strobe.wrPass) burstCnt <= burstCnt + BC_W'(1);
      if (issue && phase == PH_FILL) begin
        wrAddr   <= fillAddr;
        burstCnt <= '0;
        if (imageDone) phase <= PH_READ;
      end
      if (issue && phase == PH_READ)
        rdAddr <= (rdNext == endAddr) ? baseAddr : rdNext;
      outstanding <= outstanding
                   + ((issue && phase == PH_READ) ? LVL_W'(rdWords) : LVL_W'(0))
                   - (rdEn ? LVL_W'(1) : LVL_W'(0));
    end
  end

endmodule

// File: rtl/strm_pf_dp.sv
module strm_pf_dp
  import strm_pf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfStrobe_t         strobe,
  input  logic [DATA_W-1:0] fillData,
  input  logic [DATA_W-1:0] rdData,
  input  logic [LVL_W-1:0]  startLevel,
  input  logic              outReady,
  output logic              wrEn,
  output logic [DATA_W-1:0] wrData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              underflowErr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2  = ((1 << PTR_W) == DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrPtrNxt, rdPtrNxt;
  logic [LVL_W-1:0]  level;
  logic              started, errQ, pop;

  generate
    if (POW2) begin : g_wrapFree
      assign wrPtrNxt = wrPtr + PTR_W'(1);
      assign rdPtrNxt = rdPtr + PTR_W'(1);
    end else begin : g_wrapCmp
      assign wrPtrNxt = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      assign rdPtrNxt = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  assign wrEn         = strobe.wrPass;
  assign wrData       = fillData;
  assign fifoLevel    = level;
  assign outValid     = started && (level != '0);
  assign outData      = store[rdPtr];
  assign pop          = outValid && outReady;
  assign underflowErr = errQ;

  always_ff @(posedge clk) begin
    if (strobe.xfer) store[wrPtr] <= rdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      started <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (strobe.xfer) wrPtr <= wrPtrNxt;
      if (pop)         rdPtr <= rdPtrNxt;
      case ({strobe.xfer, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
      if (level >= startLevel) started <= 1'b1;
      if (started && outReady && (level == '0)) errQ <= 1'b1;
    end
  end

endmodule

// File: rtl/strm_pf_top.sv
module strm_pf_top
  import strm_pf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 30,
  parameter int DEPTH     = 128,
  parameter int MAX_BURST = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            baseAddr,
  input  logic [ADDR_W-1:0]            endAddr,
  input  logic [$clog2(DEPTH+1)-1:0]   startLevel,
  input  logic                         fillValid,
  input  logic [DATA_W-1:0]            fillData,
  output logic                         fillReady,
  output logic                         wrEn,
  output logic [DATA_W-1:0]            wrData,
  output logic                         cmdEn,
  output logic [2:0]                   cmdInstr,
  output logic [ADDR_W-1:0]            cmdAddr,
  output logic [5:0]                   cmdBl,
  input  logic                         cmdFull,
  output logic                         rdEn,
  input  logic [DATA_W-1:0]            rdData,
  input  logic                         rdEmpty,
  output logic                         outValid,
  output logic [DATA_W-1:0]            outData,
  input  logic                         outReady,
  output logic                         underflowErr
);

  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int BL_W  = 6;

  pfStrobe_t        strobe;
  logic [LVL_W-1:0] fifoLevel;

  strm_pf_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .MAX_BURST(MAX_BURST), .LVL_W(LVL_W), .BL_W(BL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .endAddr(endAddr),
    .fillValid(fillValid), .fillReady(fillReady),
    .cmdEn(cmdEn), .cmdInstr(cmdInstr), .cmdAddr(cmdAddr), .cmdBl(cmdBl), .cmdFull(cmdFull),
    .rdEmpty(rdEmpty), .rdEn(rdEn), .fifoLevel(fifoLevel), .strobe(strobe)
  );

  strm_pf_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillData(fillData), .rdData(rdData),
    .startLevel(startLevel), .outReady(outReady), .wrEn(wrEn), .wrData(wrData),
    .fifoLevel(fifoLevel), .outValid(outValid), .outData(outData),
    .underflowErr(underflowErr)
  );

endmodule

// File: rtl/strm_pf_checker.sv
module strm_pf_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [ADDR_W-1:0] endAddr,
  input logic              cmdEn,
  input logic [2:0]        cmdInstr,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [5:0]        cmdBl,
  input logic              cmdFull,
  input logic              rdEn,
  input logic              rdEmpty,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady,
  input logic              underflowErr
);

  logic seenRead;
  always_ff @(posedge clk) begin
    if (!rstN) seenRead <= 1'b0;
    else if (cmdEn && cmdInstr == 3'b001) seenRead <= 1'b1;
  end

  assert_no_write_after_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEn && seenRead) |-> (cmdInstr == 3'b001));

  assert_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdEn |-> (cmdAddr >= baseAddr && cmdAddr < endAddr));

  assert_even_burst_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdEn |-> cmdBl[0]);

  assert_no_cross_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdEn |-> ((ADDR_W+1)'(cmdAddr) + (((ADDR_W+1)'(cmdBl) + (ADDR_W+1)'(1)) << 2)
               <= (ADDR_W+1)'(endAddr)));

  assert_cmd_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdEn |-> !cmdFull);

  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !rdEmpty);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_sticky_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr);

endmodule

bind strm_pf_top strm_pf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .endAddr(endAddr),
  .cmdEn(cmdEn), .cmdInstr(cmdInstr), .cmdAddr(cmdAddr), .cmdBl(cmdBl), .cmdFull(cmdFull),
  .rdEn(rdEn), .rdEmpty(rdEmpty), .outValid(outValid), .outData(outData),
  .outReady(outReady), .underflowErr(underflowErr)
);

// File: tb/strm_pf_top_bench.sv
module strm_pf_top_bench;

  localparam int AW    = 30;
  localparam int DW    = 32;
  localparam int DEPTH = 128;
  localparam int MAXB  = 32;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NW    = 200;
  localparam int LAT   = 12;
  localparam int THR   = 48;
  localparam int PHA   = 4000;
  localparam int PHB   = 400;
  localparam logic [AW-1:0] BASE = AW'(32'h100);
  localparam logic [AW-1:0] ENDA = BASE + AW'(NW * 4);

  logic clk = 1'b0;
  logic rstN;
  logic [AW-1:0] baseAddr, endAddr;
  logic [LW-1:0] startLevel;
  logic fillValid, fillReady, wrEn, cmdEn, cmdFull, rdEn, rdEmpty;
  logic outValid, outReady, underflowErr;
  logic [DW-1:0] fillData, wrData, rdData, outData;
  logic [2:0] cmdInstr;
  logic [AW-1:0] cmdAddr;
  logic [5:0] cmdBl;

  always #4 clk = ~clk;

  strm_pf_top #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH), .MAX_BURST(MAXB)) u_strm_pf_top (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .endAddr(endAddr), .startLevel(startLevel),
    .fillValid(fillValid), .fillData(fillData), .fillReady(fillReady),
    .wrEn(wrEn), .wrData(wrData), .cmdEn(cmdEn), .cmdInstr(cmdInstr), .cmdAddr(cmdAddr),
    .cmdBl(cmdBl), .cmdFull(cmdFull), .rdEn(rdEn), .rdData(rdData), .rdEmpty(rdEmpty),
    .outValid(outValid), .outData(outData), .outReady(outReady), .underflowErr(underflowErr)
  );

  int compared = 0;
  int mismatched = 0;

  function automatic logic [31:0] img(int i);
    return (32'(i) * 32'h0001_0203) ^ 32'h5A00_0000;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model state
  logic [31:0] mem [0:511];
  logic [31:0] wq[$];
  logic [31:0] pendW[$];
  int          pendT[$];
  logic [31:0] ctlq[$];

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int fillIdx = 0, burstW = 0, level = 0, outst = 0, popIdx = 0, rdCmds = 0;
    logic [AW-1:0] refWrAddr = BASE, refRdAddr = BASE;
    bit readPh = 1'b0, refStarted = 1'b0, refErr = 1'b0;

    rstN = 1'b0; baseAddr = BASE; endAddr = ENDA; startLevel = LW'(THR);
    fillValid = 1'b0; fillData = '0; cmdFull = 1'b0; rdEmpty = 1'b1; rdData = '0;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 outValid in reset", outValid, 0);
    chk("R9 cmdEn in reset", cmdEn, 0);
    chk("R9 rdEn in reset", rdEn, 0);
    chk("R9 wrEn in reset", wrEn, 0);
    chk("R9 underflowErr in reset", underflowErr, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int cyc = 0; cyc < PHA + PHB; cyc++) begin
      bit stallAll, refresh, wantWr, expCmd, expFillRdy, pushW, popW, readPhNow;
      int rdWordsExp;
      stallAll = (cyc >= PHA);
      refresh  = (cyc % 800) >= 760;
      readPhNow = readPh;

      // drive inputs
      cmdFull   = (cyc % 7 == 3);
      fillValid = (fillIdx < NW);
      fillData  = (fillIdx < NW) ? img(fillIdx) : 32'h0;
      rdEmpty   = (ctlq.size() == 0);
      rdData    = rdEmpty ? 32'h0 : ctlq[0];
      outReady  = stallAll ? 1'b1 : (cyc % 4 != 0);
      #1;

      // command expectations
      wantWr     = !readPh && (burstW == MAXB || (fillIdx == NW && burstW > 0));
      expFillRdy = !readPh && !wantWr && (fillIdx < NW);
      rdWordsExp = (int'(ENDA - refRdAddr) / 4 > MAXB) ? MAXB : int'(ENDA - refRdAddr) / 4;
      expCmd     = readPh ? (!cmdFull && (DEPTH - level >= outst + rdWordsExp))
                          : (wantWr && !cmdFull);

      chk("R1 fillReady", fillReady, expFillRdy);
      chk(readPh ? "R5 cmdEn issue rule" : "R1 cmdEn write issue", cmdEn, expCmd);

      if (cmdEn) begin
        if (!readPh) begin
          chk("R1 write instr", cmdInstr, 0);
          chk("R1 write addr", cmdAddr, refWrAddr);
          chk("R1 write length", cmdBl, burstW - 1);
          for (int i = 0; i < burstW; i++) begin
            if (wq.size() > 0) mem[(int'(refWrAddr) >> 2) + i] = wq.pop_front();
          end
          refWrAddr = refWrAddr + AW'(4 * burstW);
          burstW = 0;
          if (fillIdx == NW) readPh = 1'b1;
        end else begin
          chk("R2 read instr", cmdInstr, 1);
          chk("R3 read addr", cmdAddr, refRdAddr);
          chk("R4 read length", cmdBl, rdWordsExp - 1);
          chk("R4 even word count", cmdBl % 2, 1);
          for (int i = 0; i < rdWordsExp; i++) begin
            pendW.push_back(mem[(int'(refRdAddr) >> 2) + i]);
            pendT.push_back(cyc + LAT + ((rdCmds % 5 == 4) ? 20 : 0));
          end
          outst += rdWordsExp;
          refRdAddr = refRdAddr + AW'(4 * rdWordsExp);
          if (refRdAddr == ENDA) refRdAddr = BASE;
          rdCmds++;
        end
      end

      if (fillValid && fillReady) begin
        chk("R1 wrEn", wrEn, 1);
        chk("R1 wrData", wrData, img(fillIdx));
        wq.push_back(wrData);
        fillIdx++;
        burstW++;
      end else begin
        chk("R1 wrEn idle", wrEn, 0);
      end

      // controller read queue transfer
      chk("R6 rdEn", rdEn, readPhNow && !rdEmpty);
      pushW = rdEn && !rdEmpty;
      if (pushW) begin
        void'(ctlq.pop_front());
        outst--;
      end

      // output stream
      chk("R7 outValid", outValid, refStarted && level != 0);
      popW = refStarted && (level != 0) && outReady;
      if (outValid) chk("R7 outData", outData, img(popIdx % NW));
      if (popW) popIdx++;
      chk("R8 underflowErr", underflowErr, refErr);

      refErr = refErr | (refStarted && outReady && level == 0);
      refStarted = refStarted | (level >= THR);
      level = level + int'(pushW) - int'(popW);
      if (level > DEPTH) chk("R5 local FIFO bound", level, DEPTH);

      // memory model returns one word per cycle when not frozen
      if (!refresh && !stallAll && pendW.size() > 0 && cyc >= pendT[0]) begin
        ctlq.push_back(pendW.pop_front());
        void'(pendT.pop_front());
      end

      if (cyc == PHA - 1) chk("R8 no underflow under refresh and page stalls", underflowErr, 0);
      @(negedge clk);
    end

    #1;
    chk("R3 stream wrapped past end", popIdx > NW, 1);
    chk("R8 underflow latched after frozen returns", underflowErr, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule